// File: doc/BRIEF.md
# Composite Sync Separator

This block splits an already sliced, active-low composite sync stream into a horizontal pulse and a vertical pulse. It also uses a separate periodic timing strobe, which comes from the reference clock of a timing generator. Both inputs pass through a two-flop synchronizer before their edges are detected. Every falling sync edge produces a one-cycle horizontal pulse.

Vertical detection starts from the length of each LOW stretch of sync. A clock counter measures it, and a stretch longer than a programmable threshold arms the vertical detector. The detector then fires on a rising edge of the timing strobe. A select input picks the firing rule. In the plain rule, the first timing rise after arming fires. In the strict rule, the block must also see a falling sync edge inside the next LOW phase of the timing strobe before it fires at the end of that phase. A status flag reports whether the sync level before the vertical interval matches the sync level at the firing point.

Top module: `csync_separator`

## Requirements
- R1: `hsep_o` is high for exactly one clock cycle for each falling edge of `sync_in`. It is seen in the cycle after the second rising clock edge that samples `sync_in` low.
- R2: A LOW stretch of `sync_in` arms vertical detection only if it lasts strictly more than `width_thresh` clock cycles. A stretch of exactly `width_thresh` cycles does not arm it.
- R3: The width counter saturates at 2^CNT_W-1 instead of wrapping. A very long LOW stretch still arms when `width_thresh` is below that maximum. With `width_thresh` at the maximum, nothing ever arms.
- R4: With `method_sel`=0, `vsep_o` pulses on the first timing rise that follows arming. It is seen in the cycle after the third clock edge that samples `tim_in` high. A timing rise in the same cycle as the arming event does not fire.
- R5: With `method_sel`=1, `vsep_o` pulses on the timing rise that ends the first timing LOW phase after arming, and only if a falling sync edge lands inside that phase. The phase includes the cycle in which the timing fall is detected and the cycle in which the timing rise is detected.
- R6: In the strict rule, a LOW phase with no falling sync edge produces no pulse and disarms the detector. A later timing rise under `method_sel`=0 then does not fire.
- R7: When `vsep_o` fires, `shape_flag_o` is loaded with A xor B and holds that value until the next pulse. A is the synchronized sync level at the timing rise PRE_OFS rises before the firing one. B is the sync level at the firing rise.
- R8: `vsep_o` is a one-cycle pulse. While `rst_n` is low, `hsep_o`, `vsep_o` and `shape_flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Composite sync, active low, logic level |
| tim_in | input | 1 | Periodic timing strobe for vertical alignment |
| method_sel | input | 1 | 0: plain vertical rule, 1: strict rule with falling-edge check |
| width_thresh | input | CNT_W | LOW-width threshold in clock cycles |
| hsep_o | output | 1 | One-shot horizontal sync pulse |
| vsep_o | output | 1 | One-shot vertical sync pulse |
| shape_flag_o | output | 1 | 1 when levels before and after the vertical interval differ |

## Verification
Two events can land in the same cycle. A sync falling edge can coincide with the timing rise that closes the strict-rule window, and an arming event can coincide with a timing rise. The bench provokes the first by driving sync low in the same step that the strobe goes high. It expects a vertical pulse, and a flag computed with B low. It provokes the second by releasing sync and raising the strobe together. It expects no pulse at that rise and exactly one pulse at the rise after it.

// File: rtl/csep_pkg.sv
package csep_pkg;
  typedef enum logic [1:0] {
    VS_IDLE  = 2'd0,
    VS_ARMED = 2'd1,
    VS_WIN   = 2'd2
  } vs_state_t;

  function automatic logic level_mismatch(input logic lvl_a, input logic lvl_b);
    return lvl_a ^ lvl_b;
  endfunction
endpackage

// File: rtl/csep_edge_sync.sv
module csep_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {(LAST+1){RST_VAL}};
    else        shreg <= {shreg[LAST-1:0], d_i};
  end

  assign lvl_o  = shreg[LAST-1];
  assign rise_o = shreg[LAST-1] & ~shreg[LAST];
  assign fall_o = ~shreg[LAST-1] & shreg[LAST];
endmodule

// File: rtl/csep_width_meter.sv
module csep_width_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             qualify_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] low_cnt;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (!lvl_i) low_cnt <= sat_step(low_cnt);
    else             low_cnt <= '0;
  end

  assign qualify_o = rise_i && (low_cnt > thresh_i);
endmodule

// File: rtl/csep_vsep_engine.sv
module csep_vsep_engine
  import csep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic method_i,
  input  logic qualify_i,
  input  logic csync_fall_i,
  input  logic tim_rise_i,
  input  logic tim_fall_i,
  output logic fire_o,
  output logic pending_o,
  output logic vsep_o
);
  vs_state_t state_q, state_d;
  logic      saw_q, saw_d, fire_d;

  always_comb begin
    state_d = state_q;
    saw_d   = 1'b0;
    fire_d  = 1'b0;
    unique case (state_q)
      VS_IDLE: begin
        if (qualify_i) state_d = VS_ARMED;
      end
      VS_ARMED: begin
        if (!method_i && tim_rise_i) begin
          fire_d  = 1'b1;
          state_d = VS_IDLE;
        end else if (method_i && tim_fall_i) begin
          saw_d   = csync_fall_i;
          state_d = VS_WIN;
        end
      end
      VS_WIN: begin
        saw_d = saw_q | csync_fall_i;
        if (tim_rise_i) begin
          fire_d  = saw_q | csync_fall_i;
          saw_d   = 1'b0;
          state_d = VS_IDLE;
        end
      end
      default: state_d = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VS_IDLE;
      saw_q   <= 1'b0;
      vsep_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      saw_q   <= saw_d;
      vsep_o  <= fire_d;
    end
  end

  assign fire_o    = fire_d;
  assign pending_o = (state_q != VS_IDLE);
endmodule

// File: rtl/csep_shape_probe.sv
module csep_shape_probe
  import csep_pkg::*;
#(
  parameter int PRE_OFS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tim_rise_i,
  input  logic csync_lvl_i,
  input  logic fire_i,
  output logic flag_o
);
  localparam int OLDEST = PRE_OFS - 1;

  logic [PRE_OFS-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= {PRE_OFS{1'b1}};
    end else if (tim_rise_i) begin
      hist[0] <= csync_lvl_i;
      for (int i = 1; i < PRE_OFS; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (fire_i) flag_o <= level_mismatch(hist[OLDEST], csync_lvl_i);
  end
endmodule

// File: rtl/csync_separator.sv
module csync_separator #(
  parameter int CNT_W       = 8,
  parameter int PRE_OFS     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             tim_in,
  input  logic             method_sel,
  input  logic [CNT_W-1:0] width_thresh,
  output logic             hsep_o,
  output logic             vsep_o,
  output logic             shape_flag_o
);
  localparam int NSIG  = 2;
  localparam int IDX_S = 0;
  localparam int IDX_T = 1;

  logic [NSIG-1:0] raw_in, lvl_w, rise_w, fall_w;

  assign raw_in[IDX_S] = sync_in;
  assign raw_in[IDX_T] = tim_in;

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    csep_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (raw_in[g]),
      .lvl_o  (lvl_w[g]),
      .rise_o (rise_w[g]),
      .fall_o (fall_w[g])
    );
  end

  logic csync_lvl, csync_rise, csync_fall;
  logic tim_lvl, tim_rise, tim_fall;
  logic qualify, fire, eng_pending;

  assign csync_lvl  = lvl_w[IDX_S];
  assign csync_rise = rise_w[IDX_S];
  assign csync_fall = fall_w[IDX_S];
  assign tim_lvl    = lvl_w[IDX_T];
  assign tim_rise   = rise_w[IDX_T];
  assign tim_fall   = fall_w[IDX_T];

  csep_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (csync_lvl),
    .rise_i    (csync_rise),
    .thresh_i  (width_thresh),
    .qualify_o (qualify)
  );

  csep_vsep_engine u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .method_i     (method_sel),
    .qualify_i    (qualify),
    .csync_fall_i (csync_fall),
    .tim_rise_i   (tim_rise),
    .tim_fall_i   (tim_fall),
    .fire_o       (fire),
    .pending_o    (eng_pending),
    .vsep_o       (vsep_o)
  );

  csep_shape_probe #(.PRE_OFS(PRE_OFS)) u_shape (
    .clk         (clk),
    .rst_n       (rst_n),
    .tim_rise_i  (tim_rise),
    .csync_lvl_i (csync_lvl),
    .fire_i      (fire),
    .flag_o      (shape_flag_o)
  );

  assign hsep_o = csync_fall;
endmodule

// File: rtl/csync_separator_checker.sv
module csync_separator_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsep_o,
  input logic             vsep_o,
  input logic             shape_flag_o,
  input logic [CNT_W-1:0] width_thresh,
  input logic             tim_lvl,
  input logic             qualify,
  input logic             eng_pending
);
  assert_hsep_one_shot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hsep_o |=> !hsep_o);

  assert_vsep_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vsep_o |=> !vsep_o);

  assert_vsep_on_timing_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vsep_o |-> ($past(tim_lvl) && !$past(tim_lvl, 2)));

  assert_flag_moves_with_vsep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shape_flag_o) |-> vsep_o);

  assert_no_arm_at_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |-> (width_thresh != {CNT_W{1'b1}}));

  assert_vsep_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vsep_o |-> !eng_pending);
endmodule

bind csync_separator csync_separator_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hsep_o       (hsep_o),
  .vsep_o       (vsep_o),
  .shape_flag_o (shape_flag_o),
  .width_thresh (width_thresh),
  .tim_lvl      (tim_lvl),
  .qualify      (qualify),
  .eng_pending  (eng_pending)
);

// File: tb/csync_separator_bench.sv
`timescale 1ns/1ps
module csync_separator_bench;
  localparam int CW   = 8;
  localparam int PRE  = 2;
  localparam int WLEN = 6;
  localparam int NONE = 15;
  localparam int NV   = 9;

  // vector: {method, pre_low, width[5:0], fall_ofs[3:0], exp_vsep, exp_flag}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd40, 4'd15, 1'b1, 1'b0},
    {1'b0, 1'b0, 6'd20, 4'd15, 1'b0, 1'b0},
    {1'b0, 1'b1, 6'd21, 4'd15, 1'b1, 1'b1},
    {1'b1, 1'b0, 6'd40, 4'd15, 1'b0, 1'b1},
    {1'b1, 1'b0, 6'd40, 4'd3,  1'b1, 1'b0},
    {1'b1, 1'b1, 6'd40, 4'd0,  1'b1, 1'b1},
    {1'b1, 1'b1, 6'd40, 4'd6,  1'b1, 1'b0},
    {1'b1, 1'b0, 6'd20, 4'd3,  1'b0, 1'b0},
    {1'b0, 1'b0, 6'd40, 4'd6,  1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b1;
  logic tim_in = 1'b1;
  logic method_sel = 1'b0;
  logic [CW-1:0] width_thresh = 8'd20;
  logic hsep_o, vsep_o, shape_flag_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, hcnt = 0, vcnt = 0, hlast = -1, vlast = -1;

  always #4 clk = ~clk;

  csync_separator #(.CNT_W(CW), .PRE_OFS(PRE), .SYNC_STAGES(2)) u_csync_separator (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .tim_in(tim_in),
    .method_sel(method_sel), .width_thresh(width_thresh),
    .hsep_o(hsep_o), .vsep_o(vsep_o), .shape_flag_o(shape_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic t);
    sync_in = s;
    tim_in  = t;
    @(posedge clk);
    #1;
    cyc++;
    if (hsep_o) begin hcnt++; hlast = cyc; end
    if (vsep_o) begin vcnt++; vlast = cyc; end
  endtask

  task automatic clear_counts();
    hcnt = 0; vcnt = 0; hlast = -1; vlast = -1;
  endtask

  task automatic frame(input int width, input int fofs, input logic pre_low, output int rise_cyc);
    for (int p = 0; p <= PRE; p++) begin
      for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
      for (int k = 0; k < 3; k++) step(pre_low ? 1'b0 : 1'b1, 1'b1);
      step(1'b1, 1'b1);
    end
    for (int k = 0; k < width; k++) step(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1);
    rise_cyc = -1;
    for (int w = 0; w < WLEN + 6; w++) begin
      step((w == fofs || w == fofs + 1) ? 1'b0 : 1'b1, (w < WLEN) ? 1'b0 : 1'b1);
      if (w == WLEN) rise_cyc = cyc;
    end
  endtask

  task automatic timing_period();
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int rc;
    // R8: reset state, with sync toggling while reset is held
    for (int k = 0; k < 4; k++) step(k[0], 1'b1);
    chk(!hsep_o && !vsep_o && !shape_flag_o, "R8 reset outputs",
        {hsep_o, vsep_o, shape_flag_o}, 0);
    step(1'b1, 1'b1);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1);

    // R1: horizontal one-shot latency and width
    clear_counts();
    step(1'b0, 1'b1);
    chk(hsep_o == 1'b0, "R1 no pulse at first sampling edge", hsep_o, 0);
    rc = cyc;
    step(1'b0, 1'b1);
    chk(hsep_o == 1'b1, "R1 pulse after second edge", hsep_o, 1);
    step(1'b0, 1'b1);
    chk(hsep_o == 1'b0, "R1 pulse lasts one cycle", hsep_o, 0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1);
    chk(hcnt == 1 && hlast == rc + 1, "R1 single pulse position", hlast, rc + 1);

    // Vector table: R2 R4 R5 R6 R7 R1
    for (int v = 0; v < NV; v++) begin
      logic m, pl, ev, ef;
      int wd, fo, exp_h;
      {m, pl} = VEC[v][13:12];
      wd = int'(VEC[v][11:6]);
      fo = int'(VEC[v][5:2]);
      ev = VEC[v][1];
      ef = VEC[v][0];
      method_sel = m;
      width_thresh = 8'd20;
      clear_counts();
      frame(wd, fo, pl, rc);
      exp_h = (pl ? PRE + 1 : 0) + 1 + ((fo != NONE) ? 1 : 0);
      chk(vcnt == int'(ev), $sformatf("R2/R4/R5 vector %0d vsep count", v), vcnt, int'(ev));
      if (ev) chk(vlast == rc + 2, $sformatf("R4 vector %0d vsep cycle", v), vlast - rc, 2);
      chk(shape_flag_o == ef, $sformatf("R7 vector %0d shape flag", v), shape_flag_o, ef);
      chk(hcnt == exp_h, $sformatf("R1 vector %0d hsep count", v), hcnt, exp_h);
    end

    // R6: strict-rule miss disarms; a plain-rule rise afterwards must not fire
    method_sel = 1'b1;
    clear_counts();
    frame(40, NONE, 1'b0, rc);
    method_sel = 1'b0;
    timing_period();
    timing_period();
    chk(vcnt == 0, "R6 disarmed after missing falling edge", vcnt, 0);

    // R4: arming and timing rise in the same cycle do not fire; next rise does
    method_sel = 1'b0;
    clear_counts();
    for (int k = 0; k < 30; k++) step(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1);
    chk(vcnt == 0, "R4 coincident arm and rise ignored", vcnt, 0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    rc = cyc;
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1);
    chk(vcnt == 1 && vlast == rc + 2, "R4 fires on following rise", vlast - rc, 2);

    // R3: saturation keeps a long stretch qualifying; max threshold never arms
    width_thresh = 8'd254;
    clear_counts();
    for (int k = 0; k < 300; k++) step(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1);
    timing_period();
    chk(vcnt == 1, "R3 saturated count still exceeds 254", vcnt, 1);
    width_thresh = 8'd255;
    clear_counts();
    for (int k = 0; k < 300; k++) step(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1);
    timing_period();
    timing_period();
    chk(vcnt == 0, "R3 threshold at maximum never arms", vcnt, 0);

    // R8: no vsep pulse wider than one cycle was observed overall
    chk(vsep_o == 1'b0, "R8 vsep idle at end", vsep_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule